// File: doc/BRIEF.md
# Asynchronous Serial Port with Byte-Wide Register Access

This block is a full-duplex asynchronous serial port that sits on an 8-bit processor bus. It has a transmitter with a one-byte holding buffer and a receiver that samples the line at sixteen times the bit rate. Both sides share a tick generator that runs from a fixed reference clock. Software selects the bit rate with a one-hot code. It can multiply that rate by eight, choose one or two stop bits, force a break, and issue a port reset. Two level outputs, one for received data and one for an empty transmit buffer, go to an external interrupt controller.

The bus has a two-bit address. Address 0 reads as status and writes as line configuration. Address 1 reads the received byte and writes the byte to send. Address 2 is a write-only command register. Reads of addresses 2 and 3 return zero. Read data is combinational from registered state. Side effects of a read, such as clearing a flag, take place at the clock edge on which the read strobe is high.

The receiver state machine has four states. RX_IDLE goes to RX_START when it sees a low sample on a tick. RX_START goes on to RX_DATA when the sample at mid start bit is still low; otherwise it returns to RX_IDLE as a false start. RX_DATA goes to RX_STOP after eight centre samples. RX_STOP returns to RX_IDLE when it samples the stop bit. The transmitter state machine also has four states. TX_IDLE goes to TX_START when a byte is waiting and a tick arrives. TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_STOP after eight bits. TX_STOP returns to TX_IDLE after one or two stop bit times. A port reset sends both machines straight to their idle states.

Top module: `sio_port`

## Requirements
- R1: After reset the status register (address 0) reads 0xA4. Its bits are: 7 transmit buffer empty, 6 received byte available, 5 pending (bit 6 OR bit 7), 4 receiving, 3 in stop bit, 2 synchronised receive line level, 1 overrun, 0 framing error.
- R2: Configuration bits 6..0 are a one-hot rate code. From bit 0 upward the rates are 110, 150, 300, 1200, 2400, 4800 and 9600 baud. One bit lasts 16 ticks, and one tick lasts CLK_HZ/(16·rate) reference clocks.
- R3: Command bit 4 set makes every bit period eight times shorter.
- R4: A transmitted frame is a low start bit, then 8 data bits LSB first, then stop bits at mark level. Configuration bit 7 = 1 gives one stop bit; 0 gives two. An idle line is at mark (1).
- R5: Writing address 1 clears status bit 7 (and tx_empty_evt). Bit 7 sets again when the shift register takes the byte at the start of its frame.
- R6: The receiver confirms a start bit at mid-bit and ignores a low pulse shorter than half a bit. When a byte completes, status bit 6 and rx_ready_evt go high and address 1 returns the byte. Reading address 1 clears bit 6.
- R7: If a byte completes while bit 6 is still set, status bit 1 sets and the new byte replaces the old one. A read of address 0 clears bit 1.
- R8: A frame whose stop bit samples low sets status bit 0, and its byte is still delivered. The next frame with a good stop bit clears bit 0.
- R9: Status bit 4 is high from start-bit confirmation until the stop-bit sample. Status bit 3 is high only between the last data sample and the stop-bit sample.
- R10: While command bit 1 is set, txd is held low.
- R11: Writing command bit 0 resets the port in one cycle. It clears all flags, the pending byte, the multiplier and break, and returns both state machines to idle. The configuration is kept, and the reset bit is not stored.
- R12: With an all-zero rate code no tick occurs, so a written byte stays pending and txd stays at mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Port selected |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_ready_evt | output | 1 | Received byte available |
| tx_empty_evt | output | 1 | Transmit buffer empty |

## Verification
A receiver that leaves RX_IDLE at the wrong time, or counts ticks wrongly, shows up in two ways. Status bits 4 and 3 rise at the wrong point in the frame, and a wrong byte appears at address 1 one frame later. A transmitter counting error shows on txd within one bit time, as a misplaced edge that the frame decoder catches at the next centre sample. A flag that fails to set or clear, such as empty, available, overrun or framing, is visible in the very next status read after the event that should have changed it.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int DATA_W = 8;
    localparam int OSR    = 16;
    localparam int RATE_N = 7;
    localparam int CNT_W  = $clog2(OSR);
    localparam int BIT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;

    function automatic int unsigned rate_hz(input int idx);
        case (idx)
            0: return 110;
            1: return 150;
            2: return 300;
            3: return 1200;
            4: return 2400;
            5: return 4800;
            default: return 9600;
        endcase
    endfunction

    function automatic int unsigned tick_div(input int unsigned clk_hz, input int idx, input bit fast);
        int unsigned d;
        d = clk_hz / (OSR * rate_hz(idx));
        if (fast) d = d / 8;
        if (d == 0) d = 1;
        return d;
    endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud
    import sio_pkg::*;
#(
    parameter int unsigned CLK_HZ = 4915200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RATE_N-1:0] rate_sel,
    input  logic              x8,
    output logic              tick
);
    localparam int unsigned SLOWEST = tick_div(CLK_HZ, 0, 1'b0);
    localparam int DIV_W = $clog2(SLOWEST + 1);

    logic [DIV_W-1:0] div_norm [RATE_N];
    logic [DIV_W-1:0] div_fast [RATE_N];
    logic [DIV_W-1:0] sel_div;
    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;
    logic             en;

    for (genvar g = 0; g < RATE_N; g++) begin : g_div
        assign div_norm[g] = DIV_W'(tick_div(CLK_HZ, g, 1'b0));
        assign div_fast[g] = DIV_W'(tick_div(CLK_HZ, g, 1'b1));
    end

    // Lowest set bit of the rate code wins
    always_comb begin
        sel_div = '0;
        for (int i = RATE_N - 1; i >= 0; i--) begin
            if (rate_sel[i]) sel_div = x8 ? div_fast[i] : div_norm[i];
        end
    end

    assign en = |rate_sel;

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q >= sel_div - 1'b1) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              rxd,
    output logic              line,
    output logic [DATA_W-1:0] data,
    output logic              done,
    output logic              good,
    output logic              busy,
    output logic              in_stop
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    logic              s1_q, s2_q;
    rx_state_t         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              done_q, done_d, good_q, good_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            done_q <= 1'b0;
            good_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            bit_q  <= bit_d;
            sh_q   <= sh_d;
            done_q <= done_d;
            good_q <= good_d;
        end
    end

    // Next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        bit_d  = bit_q;
        sh_d   = sh_q;
        done_d = 1'b0;
        good_d = 1'b0;
        if (tick) begin
            unique case (st_q)
                RX_IDLE: begin
                    if (!s2_q) begin
                        st_d  = RX_START;
                        cnt_d = '0;
                    end
                end
                RX_START: begin
                    if (cnt_q == CNT_MID) begin
                        if (!s2_q) begin
                            st_d  = RX_DATA;
                            cnt_d = '0;
                            bit_d = '0;
                        end else begin
                            st_d = RX_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == CNT_LAST) begin
                        sh_d  = {s2_q, sh_q[DATA_W-1:1]};
                        cnt_d = '0;
                        if (bit_q == BIT_LAST) st_d = RX_STOP;
                        else bit_d = bit_q + 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt_q == CNT_LAST) begin
                        done_d = 1'b1;
                        good_d = s2_q;
                        st_d   = RX_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: st_d = RX_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        in_stop = 1'b0;
        unique case (st_q)
            RX_DATA: busy = 1'b1;
            RX_STOP: begin
                busy    = 1'b1;
                in_stop = 1'b1;
            end
            default: ;
        endcase
    end

    assign line = s2_q;
    assign data = sh_q;
    assign done = done_q;
    assign good = good_q;
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              two_stop,
    output logic              take,
    output logic              line,
    output logic              busy
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    tx_state_t         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              stop2_q, stop2_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q    <= TX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            stop2_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            stop2_q <= stop2_d;
        end
    end

    // Next state
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        bit_d   = bit_q;
        sh_d    = sh_q;
        stop2_d = stop2_q;
        take    = 1'b0;
        if (tick && !clr) begin
            unique case (st_q)
                TX_IDLE: begin
                    if (hold_valid) begin
                        take  = 1'b1;
                        sh_d  = hold_data;
                        cnt_d = '0;
                        st_d  = TX_START;
                    end
                end
                TX_START: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_d = '0;
                        bit_d = '0;
                        st_d  = TX_DATA;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                TX_DATA: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_d = '0;
                        sh_d  = {1'b0, sh_q[DATA_W-1:1]};
                        if (bit_q == BIT_LAST) begin
                            st_d    = TX_STOP;
                            stop2_d = two_stop;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_d = '0;
                        if (stop2_q) stop2_d = 1'b0;
                        else st_d = TX_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: st_d = TX_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        line = 1'b1;
        unique case (st_q)
            TX_START: line = 1'b0;
            TX_DATA:  line = sh_q[0];
            default:  line = 1'b1;
        endcase
    end

    assign busy = (st_q != TX_IDLE);
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int unsigned CLK_HZ = 4915200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       rx_ready_evt,
    output logic       tx_empty_evt
);
    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_CMD  = 2'd2;

    logic [DATA_W-1:0] cfg_q;
    logic              brk_q, x8_q;
    logic [DATA_W-1:0] rx_hold_q, tx_hold_q;
    logic              rx_avail_q, tx_full_q, ovr_q, fe_q;

    logic wr_stat, wr_data, wr_cmd, rd_stat, rd_data, srst;
    logic tick, take, tx_line, tx_busy;
    logic rx_line, rx_done, rx_good, rx_busy, rx_in_stop;
    logic [DATA_W-1:0] rx_byte;

    assign wr_stat = bus_sel && bus_wr && bus_addr == A_STAT;
    assign wr_data = bus_sel && bus_wr && bus_addr == A_DATA;
    assign wr_cmd  = bus_sel && bus_wr && bus_addr == A_CMD;
    assign rd_stat = bus_sel && bus_rd && bus_addr == A_STAT;
    assign rd_data = bus_sel && bus_rd && bus_addr == A_DATA;
    assign srst    = wr_cmd && bus_wdata[0];

    sio_baud #(.CLK_HZ(CLK_HZ)) baud_i (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .rate_sel(cfg_q[RATE_N-1:0]), .x8(x8_q), .tick(tick)
    );

    sio_rx rx_i (
        .clk(clk), .rst_n(rst_n), .clr(srst), .tick(tick), .rxd(rxd),
        .line(rx_line), .data(rx_byte), .done(rx_done), .good(rx_good),
        .busy(rx_busy), .in_stop(rx_in_stop)
    );

    sio_tx tx_i (
        .clk(clk), .rst_n(rst_n), .clr(srst), .tick(tick),
        .hold_valid(tx_full_q), .hold_data(tx_hold_q), .two_stop(!cfg_q[7]),
        .take(take), .line(tx_line), .busy(tx_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_stat) begin
            cfg_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            brk_q      <= 1'b0;
            x8_q       <= 1'b0;
            rx_hold_q  <= '0;
            tx_hold_q  <= '0;
            rx_avail_q <= 1'b0;
            tx_full_q  <= 1'b0;
            ovr_q      <= 1'b0;
            fe_q       <= 1'b0;
        end else begin
            if (wr_cmd) begin
                brk_q <= bus_wdata[1];
                x8_q  <= bus_wdata[4];
            end
            if (rx_done) begin
                rx_hold_q  <= rx_byte;
                rx_avail_q <= 1'b1;
                fe_q       <= !rx_good;
                if (rx_avail_q && !rd_data) ovr_q <= 1'b1;
                else if (rd_stat) ovr_q <= 1'b0;
            end else begin
                if (rd_data) rx_avail_q <= 1'b0;
                if (rd_stat) ovr_q <= 1'b0;
            end
            if (wr_data) begin
                tx_hold_q <= bus_wdata;
                tx_full_q <= 1'b1;
            end else if (take) begin
                tx_full_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_STAT: bus_rdata = {!tx_full_q, rx_avail_q, rx_avail_q | !tx_full_q,
                                 rx_busy, rx_in_stop, rx_line, ovr_q, fe_q};
            A_DATA: bus_rdata = rx_hold_q;
            default: bus_rdata = '0;
        endcase
    end

    assign txd          = brk_q ? 1'b0 : tx_line;
    assign rx_ready_evt = rx_avail_q;
    assign tx_empty_evt = !tx_full_q;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic       txd,
    input logic       rx_ready_evt,
    input logic       tx_empty_evt,
    input logic       rx_done,
    input logic       rx_good,
    input logic       ovr_q,
    input logic       fe_q,
    input logic       tx_busy,
    input logic       brk_q
);
    logic soft_rst;
    assign soft_rst = bus_sel && bus_wr && bus_addr == 2'd2 && bus_wdata[0];

    // R5
    tx_wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> !tx_empty_evt);

    // R6
    rx_rd_clears_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_addr == 2'd1 && !rx_done && !soft_rst) |=> !rx_ready_evt);

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ready_evt && !(bus_sel && bus_rd && bus_addr == 2'd1) && !soft_rst) |=> ovr_q);

    // R8
    frame_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_good) |=> !fe_q);

    // R8
    frame_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_good && !soft_rst) |=> fe_q);

    // R4
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !brk_q) |-> txd);
endmodule

bind sio_port sio_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .txd(txd),
    .rx_ready_evt(rx_ready_evt), .tx_empty_evt(tx_empty_evt),
    .rx_done(rx_done), .rx_good(rx_good), .ovr_q(ovr_q), .fe_q(fe_q),
    .tx_busy(tx_busy), .brk_q(brk_q)
);

// File: tb/sio_port_tb_top.sv
module sio_port_tb_top;
    localparam int unsigned CLK_HZ = 1228800;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd, rx_ready_evt, tx_empty_evt;

    int checks = 0;
    int errors = 0;
    int bit_clks = 128;
    bit mon_en = 1'b1;
    logic [7:0] exp_q[$];
    int stops_q[$];
    logic [7:0] mon_got;
    logic [7:0] st;

    always #2.5 clk = ~clk;

    sio_port #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
        .rx_ready_evt(rx_ready_evt), .tx_empty_evt(tx_empty_evt)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    // Driver side of the scoreboard: expected frame goes into the queue first
    task automatic tx_byte(input logic [7:0] b, input int stops);
        exp_q.push_back(b);
        stops_q.push_back(stops);
        bus_write(2'd1, b);
    endtask

    task automatic wait_tx_done();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2 * bit_clks) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit stop_ok);
        rxd = 1'b0;
        repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bit_clks) @(negedge clk);
        end
        if (stop_ok) begin
            rxd = 1'b1;
            repeat (bit_clks) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (3 * bit_clks / 4) @(negedge clk);
            rxd = 1'b1;
            repeat (bit_clks / 4) @(negedge clk);
        end
        repeat (bit_clks) @(negedge clk);
    endtask

    // Monitor side of the scoreboard: decode txd frames and compare (R4)
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rst_n && txd === 1'b0) begin
                repeat (bit_clks / 2) @(negedge clk);
                chk("R4 start bit", {7'b0, txd}, 8'h00);
                for (int i = 0; i < 8; i++) begin
                    repeat (bit_clks) @(negedge clk);
                    mon_got[i] = txd;
                end
                repeat (bit_clks) @(negedge clk);
                chk("R4 first stop bit", {7'b0, txd}, 8'h01);
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected frame", mon_got, 8'hxx);
                end else begin
                    int s;
                    chk("R4 frame data", mon_got, exp_q.pop_front());
                    s = stops_q.pop_front();
                    if (s == 2) begin
                        repeat (bit_clks) @(negedge clk);
                        chk("R4 second stop bit", {7'b0, txd}, 8'h01);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        bus_read(2'd0, st);
        chk("R1 reset status", st, 8'hA4);
        bus_read(2'd1, st);
        chk("R1 reset data", st, 8'h00);

        // R12: port off, written byte stays pending
        bus_write(2'd1, 8'h55);
        repeat (2000) @(negedge clk);
        chk("R12 txd idle while off", {7'b0, txd}, 8'h01);
        bus_read(2'd0, st);
        chk("R12 status while off", st, 8'h04);
        bit_clks = 128;
        exp_q.push_back(8'h55);
        stops_q.push_back(1);
        bus_write(2'd0, 8'hC0);
        wait_tx_done();

        // R5: empty flag behaviour
        tx_byte(8'hA5, 1);
        while (txd !== 1'b0) @(negedge clk);
        bus_read(2'd0, st);
        chk("R5 empty after accept", st & 8'h80, 8'h80);
        tx_byte(8'h3C, 1);
        bus_read(2'd0, st);
        chk("R5 not empty after write", st & 8'h80, 8'h00);
        wait_tx_done();
        bus_read(2'd0, st);
        chk("R5 empty when drained", st & 8'h80, 8'h80);

        // R4: two stop bits
        bus_write(2'd0, 8'h40);
        tx_byte(8'h12, 2);
        tx_byte(8'h34, 2);
        wait_tx_done();

        // R2: 4800 baud, bit 5 of the rate code
        bus_write(2'd0, 8'hA0);
        bit_clks = 256;
        tx_byte(8'hC3, 1);
        wait_tx_done();

        // R3: x8 multiplier at 9600
        bus_write(2'd0, 8'hC0);
        bus_write(2'd2, 8'h10);
        bit_clks = 16;
        tx_byte(8'h96, 1);
        wait_tx_done();
        send_rx(8'h3B, 1'b1);
        bus_read(2'd1, st);
        chk("R3 rx byte at x8", st, 8'h3B);
        bus_write(2'd2, 8'h00);
        bit_clks = 128;

        // R6 and R9: receive with mid-frame status probes
        fork
            send_rx(8'h5A, 1'b1);
            begin
                repeat (3 * bit_clks) @(negedge clk);
                bus_read(2'd0, st);
                chk("R9 receiving, not in stop", st & 8'h18, 8'h10);
                repeat (6 * bit_clks - 2) @(negedge clk);
                bus_read(2'd0, st);
                chk("R9 in stop bit", st & 8'h18, 8'h18);
            end
        join
        bus_read(2'd0, st);
        chk("R6 available after frame", st & 8'h5B, 8'h40);
        bus_read(2'd1, st);
        chk("R6 received byte", st, 8'h5A);
        bus_read(2'd0, st);
        chk("R6 cleared by data read", st & 8'h40, 8'h00);

        // R6: short glitch is not a start bit
        rxd = 1'b0;
        repeat (bit_clks / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * bit_clks) @(negedge clk);
        bus_read(2'd0, st);
        chk("R6 glitch ignored", st & 8'h50, 8'h00);

        // R7: overrun
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        bus_read(2'd0, st);
        chk("R7 overrun set", st & 8'h42, 8'h42);
        bus_read(2'd0, st);
        chk("R7 overrun cleared by status read", st & 8'h02, 8'h00);
        bus_read(2'd1, st);
        chk("R7 newest byte kept", st, 8'h22);

        // R8: framing error and recovery
        send_rx(8'h33, 1'b0);
        bus_read(2'd0, st);
        chk("R8 framing error set", st & 8'h41, 8'h41);
        bus_read(2'd1, st);
        chk("R8 byte still delivered", st, 8'h33);
        send_rx(8'h44, 1'b1);
        bus_read(2'd0, st);
        chk("R8 cleared by good frame", st & 8'h41, 8'h40);
        bus_read(2'd1, st);
        chk("R8 good byte", st, 8'h44);

        // R10: break
        mon_en = 1'b0;
        bus_write(2'd2, 8'h02);
        repeat (50) @(negedge clk);
        chk("R10 break low", {7'b0, txd}, 8'h00);
        repeat (500) @(negedge clk);
        chk("R10 break held", {7'b0, txd}, 8'h00);
        bus_write(2'd2, 8'h00);
        chk("R10 break released", {7'b0, txd}, 8'h01);

        // R11: port reset mid-activity
        send_rx(8'h66, 1'b1);
        bus_write(2'd1, 8'h81);
        repeat (3 * bit_clks) @(negedge clk);
        bus_write(2'd1, 8'h7E);
        bus_write(2'd2, 8'h01);
        bus_read(2'd0, st);
        chk("R11 status after port reset", st, 8'hA4);
        chk("R11 txd mark after reset", {7'b0, txd}, 8'h01);
        repeat (12 * bit_clks) @(negedge clk);
        chk("R11 no frame after reset", {7'b0, txd}, 8'h01);
        bus_read(2'd0, st);
        chk("R11 pending byte dropped", st & 8'h80, 8'h80);
        mon_en = 1'b1;

        // R11: configuration kept, port still works
        tx_byte(8'hE1, 1);
        wait_tx_done();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule